// File: doc/BRIEF.md
# Memory Write-Path Fault Injector

This unit sits between a memory controller's check-bit generator and the DRAM write datapath. It corrupts the check bits and parity bits of selected writes on purpose, so that the error-detection and error-reporting software further up the stack can be tested against real faults. Software configures it through a small word-addressed register port. The configuration has three parts. First, an address filter with six fields (DIMM within its channel, rank, channel, bank, page and column), each with its own wildcard flag. Second, a check-bit mask, a choice of line half and an error type. Third, an arm bit.

Each outgoing write carries two sections: a low half and a high half of the line. Each section has `CHK_W` check bits and one parity bit. The unit fires on a write only when it is armed and every non-wildcard filter field equals the write's address. When it fires, it XORs the mask into the check bits of the chosen section(s), inverts their parity bit, or does both. All other writes pass through combinationally, with no added latency. In one-shot mode the arm bit clears itself after the first firing. In repeat mode the unit corrupts every matching write until software disarms it. A one-cycle strobe marks each firing, and a saturating counter totals the firings.

Top module: `mem_fault_inject`

## Requirements
- R1: After reset, filter registers 0..5 read 0x8000_0000 (wildcard set, value 0). Mask (6), section (7), type (8), arm (9) and count (10) read 0.
- R2: Filter registers hold field value in bits [15:0], masked to the field width, and the wildcard flag in bit 31. Register 0 is DIMM, 1 rank, 2 channel, 3 bank, 4 page and 5 column. Mask, section and type read back as written, truncated to their widths.
- R3: When a field's wildcard is clear, a write fires only if that address field equals the stored value. A mismatch in any one such field leaves the outputs equal to the inputs.
- R4: A field whose wildcard flag is set matches every address value.
- R5: While disarmed, every write passes through unchanged in the same cycle and inject_o stays low.
- R6: When type bit 1 (ECC) is set, a firing write has the mask XORed into the check bits of the selected sections. Section code 1 selects the low half (check bits [CHK_W-1:0], parity bit 0), 2 selects the high half, and 3 selects both.
- R7: When type bit 2 (parity) is set, a firing write has the parity bit of each selected section inverted. It combines with bit 1.
- R8: With type bit 0 (repeat) clear, the arm register reads 0 after the first firing, and the next matching write passes unchanged.
- R9: With type bit 0 set, every matching write fires until software writes 0 to the arm register.
- R10: inject_o is high exactly in the cycle of a firing write. The count register rises by one per firing, saturates at all-ones, and ignores register writes.
- R11: Writing any non-zero value to register 9 arms the unit (it reads back 1). Writing zero disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| wr_valid_i | input | 1 | A write is present this cycle |
| wr_dimm_i | input | DIMM_W | DIMM index within its channel |
| wr_rank_i | input | RANK_W | Rank |
| wr_chan_i | input | CHAN_W | Channel |
| wr_bank_i | input | BANK_W | Bank |
| wr_page_i | input | PAGE_W | Page (row) |
| wr_col_i | input | COL_W | Column |
| wr_check_i | input | 2*CHK_W | Check bits; low section in the low half |
| wr_par_i | input | 2 | Parity bit per section |
| wr_check_o | output | 2*CHK_W | Check bits after injection |
| wr_par_o | output | 2 | Parity bits after injection |
| inject_o | output | 1 | High during a firing write |

## Verification
The bound checker tests several properties on every cycle. Non-firing writes pass through untouched, and a disarmed unit never fires. An ECC firing on the low section flips exactly the mask bits there. A one-shot firing disarms the unit. The counter steps by one per firing and otherwise holds. The directed scenarios cover what needs a programmed sequence: the register map and its reset values, the field-by-field match against wildcards, the section encodings on the high half, combined ECC and parity types, repeat-until-disarm, and counter saturation with its write protection.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 4;
  localparam int VAL_W   = 16;
  localparam int NF      = 6;
  localparam int NSEC    = 2;
  localparam int ANY_BIT = 31;

  typedef logic [VAL_W-1:0] fval_t;

  localparam logic [ADDR_W-1:0] A_MASK = 4'd6;
  localparam logic [ADDR_W-1:0] A_SECT = 4'd7;
  localparam logic [ADDR_W-1:0] A_TYPE = 4'd8;
  localparam logic [ADDR_W-1:0] A_ARM  = 4'd9;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd10;

  localparam int T_REPEAT = 0;
  localparam int T_ECC    = 1;
  localparam int T_PAR    = 2;
endpackage

// File: rtl/fi_regs.sv
module fi_regs
  import fi_pkg::*;
#(
  parameter int CHK_W = 8,
  parameter int CNT_W = 16,
  parameter fval_t [NF-1:0] FMASK = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic                fire_i,
  output fval_t [NF-1:0]      val_o,
  output logic [NF-1:0]       any_o,
  output logic [CHK_W-1:0]    mask_o,
  output logic [NSEC-1:0]     sect_o,
  output logic [2:0]          type_o,
  output logic                arm_o,
  output logic [CNT_W-1:0]    cnt_o
);
  fval_t [NF-1:0]   val_q;
  logic [NF-1:0]    any_q;
  logic [CHK_W-1:0] mask_q;
  logic [NSEC-1:0]  sect_q;
  logic [2:0]       type_q;
  logic             arm_q;
  logic [CNT_W-1:0] cnt_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[ANY_BIT-1:VAL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      any_q  <= '1;
      mask_q <= '0;
      sect_q <= '0;
      type_q <= '0;
      arm_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      // one-shot disarm; a same-cycle software write to arm wins
      if (fire_i && !type_q[T_REPEAT]) arm_q <= 1'b0;
      if (fire_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (we_i) begin
        for (int i = 0; i < NF; i++) begin
          if (addr_i == ADDR_W'(i)) begin
            val_q[i] <= wdata_i[VAL_W-1:0] & FMASK[i];
            any_q[i] <= wdata_i[ANY_BIT];
          end
        end
        case (addr_i)
          A_MASK:  mask_q <= wdata_i[CHK_W-1:0];
          A_SECT:  sect_q <= wdata_i[NSEC-1:0];
          A_TYPE:  type_q <= wdata_i[2:0];
          A_ARM:   arm_q  <= |wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NF; i++) begin
      if (addr_i == ADDR_W'(i)) begin
        rdata_o[ANY_BIT]     = any_q[i];
        rdata_o[VAL_W-1:0]   = val_q[i];
      end
    end
    case (addr_i)
      A_MASK:  rdata_o = REG_W'(mask_q);
      A_SECT:  rdata_o = REG_W'(sect_q);
      A_TYPE:  rdata_o = REG_W'(type_q);
      A_ARM:   rdata_o = REG_W'(arm_q);
      A_CNT:   rdata_o = REG_W'(cnt_q);
      default: ;
    endcase
  end

  assign val_o  = val_q;
  assign any_o  = any_q;
  assign mask_o = mask_q;
  assign sect_o = sect_q;
  assign type_o = type_q;
  assign arm_o  = arm_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/fi_match.sv
module fi_match
  import fi_pkg::*;
(
  input  fval_t [NF-1:0] addr_i,
  input  fval_t [NF-1:0] val_i,
  input  logic  [NF-1:0] any_i,
  output logic           hit_o
);
  logic [NF-1:0] field_hit;

  for (genvar g = 0; g < NF; g++) begin : g_field
    assign field_hit[g] = any_i[g] || (addr_i[g] == val_i[g]);
  end

  assign hit_o = &field_hit;
endmodule

// File: rtl/fi_corrupt.sv
module fi_corrupt
  import fi_pkg::*;
#(
  parameter int CHK_W = 8
) (
  input  logic                  fire_i,
  input  logic [NSEC-1:0]       sect_i,
  input  logic [2:0]            type_i,
  input  logic [CHK_W-1:0]      mask_i,
  input  logic [NSEC*CHK_W-1:0] check_i,
  input  logic [NSEC-1:0]       par_i,
  output logic [NSEC*CHK_W-1:0] check_o,
  output logic [NSEC-1:0]       par_o
);
  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic sel;
    assign sel = fire_i && sect_i[s];
    assign check_o[s*CHK_W +: CHK_W] = check_i[s*CHK_W +: CHK_W]
                                     ^ ((sel && type_i[T_ECC]) ? mask_i : '0);
    assign par_o[s] = par_i[s] ^ (sel && type_i[T_PAR]);
  end
endmodule

// File: rtl/mem_fault_inject.sv
module mem_fault_inject
  import fi_pkg::*;
#(
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int CHAN_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 10,
  parameter int CHK_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [REG_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]      reg_rdata_o,
  input  logic                  wr_valid_i,
  input  logic [DIMM_W-1:0]     wr_dimm_i,
  input  logic [RANK_W-1:0]     wr_rank_i,
  input  logic [CHAN_W-1:0]     wr_chan_i,
  input  logic [BANK_W-1:0]     wr_bank_i,
  input  logic [PAGE_W-1:0]     wr_page_i,
  input  logic [COL_W-1:0]      wr_col_i,
  input  logic [NSEC*CHK_W-1:0] wr_check_i,
  input  logic [NSEC-1:0]       wr_par_i,
  output logic [NSEC*CHK_W-1:0] wr_check_o,
  output logic [NSEC-1:0]       wr_par_o,
  output logic                  inject_o
);
  localparam fval_t ONES = '1;
  localparam fval_t M_DIMM = ONES >> (VAL_W - DIMM_W);
  localparam fval_t M_RANK = ONES >> (VAL_W - RANK_W);
  localparam fval_t M_CHAN = ONES >> (VAL_W - CHAN_W);
  localparam fval_t M_BANK = ONES >> (VAL_W - BANK_W);
  localparam fval_t M_PAGE = ONES >> (VAL_W - PAGE_W);
  localparam fval_t M_COL  = ONES >> (VAL_W - COL_W);
  localparam fval_t [NF-1:0] FMASK = {M_COL, M_PAGE, M_BANK, M_CHAN, M_RANK, M_DIMM};

  fval_t [NF-1:0]   addr_v;
  fval_t [NF-1:0]   val_q;
  logic [NF-1:0]    any_q;
  logic [CHK_W-1:0] mask_q;
  logic [NSEC-1:0]  sect_q;
  logic [2:0]       type_q;
  logic             arm_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;
  logic             fire;

  assign addr_v = {fval_t'(wr_col_i), fval_t'(wr_page_i), fval_t'(wr_bank_i),
                   fval_t'(wr_chan_i), fval_t'(wr_rank_i), fval_t'(wr_dimm_i)};

  fi_regs #(.CHK_W(CHK_W), .CNT_W(CNT_W), .FMASK(FMASK)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .fire_i  (fire),
    .val_o   (val_q),
    .any_o   (any_q),
    .mask_o  (mask_q),
    .sect_o  (sect_q),
    .type_o  (type_q),
    .arm_o   (arm_q),
    .cnt_o   (cnt_q)
  );

  fi_match u_match (
    .addr_i (addr_v),
    .val_i  (val_q),
    .any_i  (any_q),
    .hit_o  (hit)
  );

  assign fire     = wr_valid_i && arm_q && hit;
  assign inject_o = fire;

  fi_corrupt #(.CHK_W(CHK_W)) u_corrupt (
    .fire_i  (fire),
    .sect_i  (sect_q),
    .type_i  (type_q),
    .mask_i  (mask_q),
    .check_i (wr_check_i),
    .par_i   (wr_par_i),
    .check_o (wr_check_o),
    .par_o   (wr_par_o)
  );
endmodule

// File: rtl/fi_checker.sv
module fi_checker
  import fi_pkg::*;
#(
  parameter int CHK_W = 8,
  parameter int CNT_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_we_i,
  input logic [ADDR_W-1:0]     reg_addr_i,
  input logic                  wr_valid_i,
  input logic [NSEC*CHK_W-1:0] wr_check_i,
  input logic [NSEC-1:0]       wr_par_i,
  input logic [NSEC*CHK_W-1:0] wr_check_o,
  input logic [NSEC-1:0]       wr_par_o,
  input logic                  inject_o,
  input logic                  arm_q,
  input logic [2:0]            type_q,
  input logic [NSEC-1:0]       sect_q,
  input logic [CHK_W-1:0]      mask_q,
  input logic [CNT_W-1:0]      cnt_q
);
  logic [NSEC*CHK_W-1:0] diff;
  assign diff = wr_check_o ^ wr_check_i;

  AST_PASS_UNCHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inject_o |-> (wr_check_o == wr_check_i && wr_par_o == wr_par_i)); // R3
  AST_DISARMED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_q |-> !inject_o); // R5
  AST_FIRE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_o |-> wr_valid_i); // R10
  AST_ECC_LOW_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inject_o && type_q[T_ECC] && sect_q[0]) |-> diff[CHK_W-1:0] == mask_q); // R6
  AST_ONESHOT_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inject_o && !type_q[T_REPEAT] && !(reg_we_i && reg_addr_i == A_ARM)) |=> !arm_q); // R8
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inject_o && cnt_q != '1) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R10
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inject_o |=> $stable(cnt_q)); // R10
endmodule

bind mem_fault_inject fi_checker #(.CHK_W(CHK_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .wr_valid_i (wr_valid_i),
  .wr_check_i (wr_check_i),
  .wr_par_i   (wr_par_i),
  .wr_check_o (wr_check_o),
  .wr_par_o   (wr_par_o),
  .inject_o   (inject_o),
  .arm_q      (arm_q),
  .type_q     (type_q),
  .sect_q     (sect_q),
  .mask_q     (mask_q),
  .cnt_q      (cnt_q)
);

// File: tb/mem_fault_inject_test.sv
module mem_fault_inject_test;
  localparam int CNT_W = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_dimm = '0;
  logic [1:0]  wr_rank = '0;
  logic [1:0]  wr_chan = '0;
  logic [2:0]  wr_bank = '0;
  logic [15:0] wr_page = '0;
  logic [9:0]  wr_col = '0;
  logic [15:0] wr_check = '0;
  logic [1:0]  wr_par = '0;
  logic [15:0] check_o;
  logic [1:0]  par_o;
  logic        inject;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;

  always #10ns clk = ~clk;

  mem_fault_inject #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .wr_valid_i(wr_valid), .wr_dimm_i(wr_dimm), .wr_rank_i(wr_rank), .wr_chan_i(wr_chan),
    .wr_bank_i(wr_bank), .wr_page_i(wr_page), .wr_col_i(wr_col),
    .wr_check_i(wr_check), .wr_par_i(wr_par),
    .wr_check_o(check_o), .wr_par_o(par_o), .inject_o(inject)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata, exp, tag);
  endtask

  // drive one write, check combinational outputs, let it commit
  task automatic mem_wr(input logic [2:0] chan, input logic [2:0] bank, input logic [15:0] chk_in,
                        input logic [1:0] par_in, input logic exp_inj, input logic [15:0] exp_chk,
                        input logic [1:0] exp_par, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_chan = chan[1:0]; wr_bank = bank; wr_check = chk_in; wr_par = par_in;
    wr_dimm = 2'd1; wr_rank = 2'd3; wr_page = 16'hBEEF; wr_col = 10'h155;
    #1;
    chk({31'b0, inject}, {31'b0, exp_inj}, {tag, " inject"});
    chk({16'b0, check_o}, {16'b0, exp_chk}, {tag, " check"});
    chk({30'b0, par_o}, {30'b0, exp_par}, {tag, " parity"});
    @(posedge clk);
    if (exp_inj && exp_cnt < (1 << CNT_W) - 1) exp_cnt++;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) reg_rd(4'(i), 32'h8000_0000, "R1 filter reset");
    for (int i = 6; i < 11; i++) reg_rd(4'(i), 32'h0, "R1 control reset");
  endtask

  task automatic t_readback();
    reg_wr(4'd0, 32'h0000_FFFF); reg_rd(4'd0, 32'h0000_0003, "R2 dimm width mask");
    reg_wr(4'd4, 32'h8000_1234); reg_rd(4'd4, 32'h8000_1234, "R2 page");
    reg_wr(4'd5, 32'h0000_07FF); reg_rd(4'd5, 32'h0000_03FF, "R2 column width mask");
    reg_wr(4'd6, 32'h0000_01A5); reg_rd(4'd6, 32'h0000_00A5, "R2 mask");
    reg_wr(4'd7, 32'h0000_0003); reg_rd(4'd7, 32'h0000_0003, "R2 section");
    reg_wr(4'd8, 32'h0000_000F); reg_rd(4'd8, 32'h0000_0007, "R2 type");
    for (int i = 0; i < 6; i++) reg_wr(4'(i), 32'h8000_0000);
    reg_wr(4'd8, 32'h0);
  endtask

  task automatic t_disabled();
    reg_wr(4'd6, 32'h3C); reg_wr(4'd7, 32'd3); reg_wr(4'd8, 32'd7);
    mem_wr(3'd0, 3'd0, 16'hF00F, 2'b01, 1'b0, 16'hF00F, 2'b01, "R5 disarmed");
  endtask

  task automatic t_ecc();
    reg_wr(4'd8, 32'd3); reg_wr(4'd9, 32'd1);
    reg_wr(4'd7, 32'd1);
    mem_wr(3'd0, 3'd0, 16'hF00F, 2'b00, 1'b1, 16'hF033, 2'b00, "R6 low section");
    reg_wr(4'd7, 32'd2);
    mem_wr(3'd0, 3'd0, 16'hF00F, 2'b00, 1'b1, 16'hCC0F, 2'b00, "R6 high section");
    reg_wr(4'd7, 32'd3);
    mem_wr(3'd0, 3'd0, 16'hF00F, 2'b11, 1'b1, 16'hCC33, 2'b11, "R6 both sections");
  endtask

  task automatic t_parity();
    reg_wr(4'd8, 32'd5); reg_wr(4'd7, 32'd3);
    mem_wr(3'd0, 3'd0, 16'h1234, 2'b01, 1'b1, 16'h1234, 2'b10, "R7 parity both");
    reg_wr(4'd8, 32'd7); reg_wr(4'd7, 32'd2);
    mem_wr(3'd0, 3'd0, 16'h1234, 2'b01, 1'b1, 16'h2E34, 2'b11, "R7 ecc plus parity high");
  endtask

  task automatic t_match();
    reg_wr(4'd8, 32'd3); reg_wr(4'd7, 32'd1);
    reg_wr(4'd2, 32'd2); reg_wr(4'd3, 32'd5);
    mem_wr(3'd2, 3'd5, 16'h0000, 2'b00, 1'b1, 16'h003C, 2'b00, "R3 full match");
    mem_wr(3'd1, 3'd5, 16'h0000, 2'b00, 1'b0, 16'h0000, 2'b00, "R3 channel mismatch");
    mem_wr(3'd2, 3'd4, 16'h0000, 2'b00, 1'b0, 16'h0000, 2'b00, "R3 bank mismatch");
    reg_wr(4'd2, 32'h8000_0000);
    mem_wr(3'd1, 3'd5, 16'h0000, 2'b00, 1'b1, 16'h003C, 2'b00, "R4 channel wildcard");
    reg_wr(4'd3, 32'h8000_0000);
    mem_wr(3'd3, 3'd6, 16'h0000, 2'b00, 1'b1, 16'h003C, 2'b00, "R4 all wildcard");
  endtask

  task automatic t_oneshot();
    reg_wr(4'd8, 32'd2);
    mem_wr(3'd0, 3'd0, 16'h0000, 2'b00, 1'b1, 16'h003C, 2'b00, "R8 first fires");
    reg_rd(4'd9, 32'd0, "R8 arm cleared");
    mem_wr(3'd0, 3'd0, 16'h0000, 2'b00, 1'b0, 16'h0000, 2'b00, "R8 second passes");
  endtask

  task automatic t_repeat();
    reg_wr(4'd8, 32'd3); reg_wr(4'd9, 32'h40);
    reg_rd(4'd9, 32'd1, "R11 nonzero arms");
    for (int i = 0; i < 3; i++)
      mem_wr(3'd0, 3'd0, 16'h0000, 2'b00, 1'b1, 16'h003C, 2'b00, "R9 repeat fires");
    reg_rd(4'd9, 32'd1, "R9 still armed");
    reg_wr(4'd9, 32'd0);
    reg_rd(4'd9, 32'd0, "R11 zero disarms");
    mem_wr(3'd0, 3'd0, 16'h0000, 2'b00, 1'b0, 16'h0000, 2'b00, "R9 after disarm");
  endtask

  task automatic t_count();
    reg_rd(4'd10, 32'(exp_cnt), "R10 count");
    reg_wr(4'd10, 32'h0);
    reg_rd(4'd10, 32'(exp_cnt), "R10 count write ignored");
    reg_wr(4'd9, 32'd1);
    for (int i = 0; i < 12; i++)
      mem_wr(3'd0, 3'd0, 16'h0000, 2'b00, 1'b1, 16'h003C, 2'b00, "R10 fill");
    reg_rd(4'd10, 32'h0000_000F, "R10 count saturates");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_disabled();
    t_ecc();
    t_parity();
    t_match();
    t_oneshot();
    t_repeat();
    t_count();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule